// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the device-side front end of a byte-wide flash interface. A host writes one byte per strobe onto an 8-bit bus. A command-latch enable marks the byte as a command, and an address-latch enable marks it as an address cycle. The decoder walks the legal sequences for these operations: page read, column relocation during read-out, page program with in-page column relocation, chained multi-bank program, copy-back, block erase, status and abort. Undefined bytes and out-of-order cycles are refused.

Each confirm byte produces a one-cycle operation strobe for the array engine. The strobe carries an opcode, a mask of the banks involved, one page address slot per bank, the last latched column and the data-input column pointer. Each data byte in a load phase is forwarded with its bank and column. The array engine pulses `done_i` when a launched operation finishes, and the decoder holds `busy_o` until then.

The byte input carries no ready signal and accepts a byte on every cycle with `wr_en` high. The operation and data outputs are valid-only pulses with no back-pressure, so the consumer must take each pulse in the cycle it appears. Column and row widths must be multiples of 8. Banks interleave on the low row bits.

Top module: `flash_seq_decoder`

## Requirements
- R1: After reset no strobe is active and `busy_o` is low. The decoder is idle, so a confirm byte written first is flagged on `seq_err`.
- R2: A byte is taken only on a cycle with `wr_en` high. With `cle` high and `ale` low it is a command. With `ale` high and `cle` low it is an address cycle. With both low it is data. With both high it is flagged. At most one of `op_valid`, `dat_valid` and `seq_err` pulses per cycle, one cycle after the byte.
- R3: Command 00h, then two column cycles and two row cycles (each field low byte first), then 30h gives `op_code` 1. The mask has the single bit of bank = row bits [BANK_W-1:0], that bank's page slot holds the row, and `op_col` holds the column.
- R4: In the read-out state, 05h, two column cycles and E0h give `op_code` 3 with the new column in `op_col` and a zero mask. This may be repeated with any column, including one given before.
- R5: Command 80h and four address cycles open a load. Each data byte then pulses `dat_valid` with the bank, the byte and a column pointer that starts at the given column and advances by one. Command 85h with two column cycles moves the pointer. Command 10h gives `op_code` 4, with `op_col` the last latched column and `op_dcol` the pointer.
- R6: In a load, 11h ends one bank's setup, and the next byte must be 80h or it is flagged. Bank bits accumulate in the mask in any order. When a bank is addressed again, its later page replaces the earlier one.
- R7: Command 00h, four address cycles and 35h give `op_code` 2. After `done_i`, 85h and four address cycles name the destination, data may follow, and 10h gives `op_code` 5 for the destination bank.
- R8: Command 60h, two row cycles and D0h give `op_code` 6 with a single-bank mask. The page slot holds the row with bit BANK_W cleared, so pages N and N+4 name the same block.
- R9: Command FFh in any state, busy included, gives `op_code` 8 with a zero mask. It clears `busy_o` and the bank mask and returns the decoder to idle.
- R10: A command byte outside {00h, 05h, 10h, 11h, 30h, 35h, 60h, 70h, 80h, 85h, D0h, E0h, FFh} pulses `seq_err`, starts nothing and returns the decoder to idle. A defined command outside its place in a sequence is handled the same way.
- R11: `busy_o` rises with `op_code` 1, 2, 4, 5 or 6 and falls one cycle after `done_i`. While busy, any byte other than 70h or FFh is flagged and leaves the sequence state unchanged.
- R12: Command 70h at any point gives `op_code` 7 with a zero mask, and it leaves both the sequence state and `busy_o` unchanged.
- R13: An address cycle outside an address phase, including a cycle beyond the phase's count, is flagged and returns the decoder to idle. A data byte outside a load phase is handled the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe, one byte per high cycle |
| cle | input | 1 | Marks the byte as a command |
| ale | input | 1 | Marks the byte as an address cycle |
| bus_d | input | 8 | Byte bus |
| done_i | input | 1 | Array engine finished the launched operation |
| busy_o | output | 1 | An operation is in progress |
| seq_err | output | 1 | Pulse: byte refused |
| op_valid | output | 1 | Pulse: operation strobe |
| op_code | output | 4 | Operation code (1..8) |
| op_mask | output | NBANK | Banks taking part |
| op_col | output | COL_W | Last latched column address |
| op_pages | output | NBANK*ROW_W | Page slot per bank, bank 0 lowest |
| op_dcol | output | COL_W | Data-input column pointer |
| dat_valid | output | 1 | Pulse: data byte for the page buffer |
| dat_bank | output | BANK_W | Bank of the data byte |
| dat_col | output | COL_W | Column of the data byte |
| dat_byte | output | 8 | Data byte |

## Verification
Every legal sequence is driven end to end: a plain read, repeated column relocations including a repeated column, a program with an in-page relocation, a three-step multi-bank chain that revisits one bank, copy-back with a data update, and erase on a row whose pair bit is set. Together these show that the bank is taken from the row, that a later page overrides an earlier one, and that the pointer restarts on relocation. Refusal is tried with undefined bytes, confirms out of place, surplus and orphan address cycles, a bad follower of 11h, both latch enables high, and bytes sent while busy. Each case is followed by a byte that reveals whether the decoder went idle or kept its state, and FFh is tried both mid-load and during busy.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;
  typedef enum logic [3:0] {
    OP_NONE = 4'd0, OP_READ = 4'd1, OP_CBREAD = 4'd2, OP_COLOUT = 4'd3,
    OP_PROG = 4'd4, OP_CBPROG = 4'd5, OP_ERASE = 4'd6, OP_STATUS = 4'd7,
    OP_RESET = 4'd8
  } op_e;

  typedef enum logic [3:0] {
    C_READ, C_RDGO, C_CBGO, C_COLSET, C_COLGO, C_PGSET, C_RELOC,
    C_NEXT, C_PGGO, C_ERSET, C_ERGO, C_STAT, C_RST, C_UNDEF
  } cmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_ADR, S_RD_CNF, S_RD_OUT, S_CO_ADR, S_CO_CNF, S_PG_ADR,
    S_PG_DAT, S_PG_REL, S_PG_NXT, S_CB_WT, S_CB_ADR, S_CB_DAT, S_ER_ADR,
    S_ER_CNF
  } st_e;

  typedef enum logic [1:0] {AF_FULL, AF_COL, AF_ROW} afmt_e;
endpackage

// File: rtl/flash_seq_classify.sv
`timescale 1ns/1ps
module flash_seq_classify
  import flash_seq_pkg::*;
(
  input  logic [7:0] byte_i,
  output cmd_e       cmd_o
);
  always_comb begin
    case (byte_i)
      8'h00:   cmd_o = C_READ;
      8'h30:   cmd_o = C_RDGO;
      8'h35:   cmd_o = C_CBGO;
      8'h05:   cmd_o = C_COLSET;
      8'hE0:   cmd_o = C_COLGO;
      8'h80:   cmd_o = C_PGSET;
      8'h85:   cmd_o = C_RELOC;
      8'h11:   cmd_o = C_NEXT;
      8'h10:   cmd_o = C_PGGO;
      8'h60:   cmd_o = C_ERSET;
      8'hD0:   cmd_o = C_ERGO;
      8'h70:   cmd_o = C_STAT;
      8'hFF:   cmd_o = C_RST;
      default: cmd_o = C_UNDEF;
    endcase
  end
endmodule

// File: rtl/flash_seq_addr.sv
`timescale 1ns/1ps
module flash_seq_addr
  import flash_seq_pkg::*;
#(
  parameter int COL_W = 16,
  parameter int ROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             take_i,
  input  afmt_e            fmt_i,
  input  logic [7:0]       byte_i,
  output logic             last_o,
  output logic [COL_W-1:0] col_o,
  output logic [COL_W-1:0] col_nx_o,
  output logic [ROW_W-1:0] row_nx_o
);
  localparam int COL_CYC = COL_W / 8;
  localparam int ROW_CYC = ROW_W / 8;
  localparam int TOT     = COL_CYC + ROW_CYC;
  localparam int CNT_W   = $clog2(TOT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  int               need;

  always_comb begin
    case (fmt_i)
      AF_COL:  need = COL_CYC;
      AF_ROW:  need = ROW_CYC;
      default: need = TOT;
    endcase
    last_o = (cnt_q == CNT_W'(need - 1));
  end

  // splice the incoming byte into its field, low byte first
  always_comb begin
    col_nx_o = col_q;
    row_nx_o = row_q;
    for (int i = 0; i < COL_CYC; i++)
      if (take_i && fmt_i != AF_ROW && cnt_q == CNT_W'(i))
        col_nx_o[i*8 +: 8] = byte_i;
    for (int j = 0; j < ROW_CYC; j++)
      if (take_i && ((fmt_i == AF_FULL && cnt_q == CNT_W'(j + COL_CYC)) ||
                     (fmt_i == AF_ROW  && cnt_q == CNT_W'(j))))
        row_nx_o[j*8 +: 8] = byte_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      col_q <= '0;
      row_q <= '0;
    end else begin
      if (clr_i)       cnt_q <= '0;
      else if (take_i) cnt_q <= cnt_q + 1'b1;
      col_q <= col_nx_o;
      row_q <= row_nx_o;
    end
  end

  assign col_o = col_q;
endmodule

// File: rtl/flash_seq_banks.sv
`timescale 1ns/1ps
module flash_seq_banks #(
  parameter int NBANK  = 4,
  parameter int ROW_W  = 16,
  parameter int BANK_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_i,
  input  logic                   wr_i,
  input  logic [BANK_W-1:0]      sel_i,
  input  logic [ROW_W-1:0]       page_i,
  output logic [NBANK-1:0]       mask_o,
  output logic [NBANK*ROW_W-1:0] pages_o
);
  for (genvar g = 0; g < NBANK; g++) begin : g_slot
    logic             hit_q;
    logic [ROW_W-1:0] pg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hit_q <= 1'b0;
        pg_q  <= '0;
      end else if (clr_i) begin
        hit_q <= 1'b0;
      end else if (wr_i && sel_i == BANK_W'(g)) begin
        hit_q <= 1'b1;
        pg_q  <= page_i;   // a later page for the same bank wins
      end
    end
    assign mask_o[g] = hit_q;
    assign pages_o[g*ROW_W +: ROW_W] = pg_q;
  end
endmodule

// File: rtl/flash_seq_decoder.sv
`timescale 1ns/1ps
module flash_seq_decoder
  import flash_seq_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int COL_W = 16,
  parameter int ROW_W = 16,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   cle,
  input  logic                   ale,
  input  logic [7:0]             bus_d,
  input  logic                   done_i,
  output logic                   busy_o,
  output logic                   seq_err,
  output logic                   op_valid,
  output logic [3:0]             op_code,
  output logic [NBANK-1:0]       op_mask,
  output logic [COL_W-1:0]       op_col,
  output logic [NBANK*ROW_W-1:0] op_pages,
  output logic [COL_W-1:0]       op_dcol,
  output logic                   dat_valid,
  output logic [BANK_W-1:0]      dat_bank,
  output logic [COL_W-1:0]       dat_col,
  output logic [7:0]             dat_byte
);
  localparam int PAIR_BIT = BANK_W;   // pages N and N+4 share a block

  st_e   st_q, st_n;
  cmd_e  cmd;
  afmt_e fmt;
  op_e   ev_op;
  logic  ev_err, ev_dat;
  logic  a_clr, a_take, a_last;
  logic  b_clr, b_wr, b_erase;
  logic  p_load, p_inc, busy_set, busy_clr;
  logic  busy_q;
  logic  is_cmd, is_adr, is_dat, is_bad;
  logic [COL_W-1:0]  col_q, col_nx, ptr_q;
  logic [ROW_W-1:0]  row_nx, b_page;
  logic [BANK_W-1:0] cur_bank_q;
  logic [NBANK-1:0]  mask;

  flash_seq_classify u_cls (.byte_i(bus_d), .cmd_o(cmd));

  flash_seq_addr #(.COL_W(COL_W), .ROW_W(ROW_W)) u_adr (
    .clk(clk), .rst_n(rst_n), .clr_i(a_clr), .take_i(a_take), .fmt_i(fmt),
    .byte_i(bus_d), .last_o(a_last), .col_o(col_q), .col_nx_o(col_nx),
    .row_nx_o(row_nx)
  );

  assign b_page = b_erase ? (row_nx & ~(ROW_W'(1) << PAIR_BIT)) : row_nx;

  flash_seq_banks #(.NBANK(NBANK), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_bnk (
    .clk(clk), .rst_n(rst_n), .clr_i(b_clr), .wr_i(b_wr),
    .sel_i(row_nx[BANK_W-1:0]), .page_i(b_page), .mask_o(mask),
    .pages_o(op_pages)
  );

  always_comb begin
    case (st_q)
      S_CO_ADR, S_PG_REL: fmt = AF_COL;
      S_ER_ADR:           fmt = AF_ROW;
      default:            fmt = AF_FULL;
    endcase
  end

  always_comb begin
    is_cmd = wr_en &  cle & ~ale;
    is_adr = wr_en &  ale & ~cle;
    is_dat = wr_en & ~cle & ~ale;
    is_bad = wr_en &  cle &  ale;
    st_n = st_q;  ev_op = OP_NONE;  ev_err = 1'b0;  ev_dat = 1'b0;
    a_clr = 1'b0; a_take = 1'b0; b_clr = 1'b0; b_wr = 1'b0; b_erase = 1'b0;
    p_load = 1'b0; p_inc = 1'b0; busy_set = 1'b0; busy_clr = 1'b0;
    if (is_bad) begin
      ev_err = 1'b1;
    end else if (is_cmd && cmd == C_STAT) begin
      ev_op = OP_STATUS;
    end else if (is_cmd && cmd == C_RST) begin
      ev_op = OP_RESET;  st_n = S_IDLE;  b_clr = 1'b1;  busy_clr = 1'b1;
    end else if (busy_q) begin
      ev_err = is_cmd | is_adr | is_dat;   // state held while busy
    end else if (is_cmd) begin
      case (cmd)
        C_READ:
          if (st_q == S_IDLE || st_q == S_RD_OUT) begin
            st_n = S_RD_ADR;  a_clr = 1'b1;  b_clr = 1'b1;
          end else ev_err = 1'b1;
        C_PGSET:
          if (st_q == S_IDLE || st_q == S_RD_OUT) begin
            st_n = S_PG_ADR;  a_clr = 1'b1;  b_clr = 1'b1;
          end else if (st_q == S_PG_NXT) begin
            st_n = S_PG_ADR;  a_clr = 1'b1;
          end else ev_err = 1'b1;
        C_ERSET:
          if (st_q == S_IDLE || st_q == S_RD_OUT) begin
            st_n = S_ER_ADR;  a_clr = 1'b1;  b_clr = 1'b1;
          end else ev_err = 1'b1;
        C_RDGO:
          if (st_q == S_RD_CNF) begin
            ev_op = OP_READ;  busy_set = 1'b1;  st_n = S_RD_OUT;
          end else ev_err = 1'b1;
        C_CBGO:
          if (st_q == S_RD_CNF) begin
            ev_op = OP_CBREAD;  busy_set = 1'b1;  st_n = S_CB_WT;
          end else ev_err = 1'b1;
        C_COLSET:
          if (st_q == S_RD_OUT) begin
            st_n = S_CO_ADR;  a_clr = 1'b1;
          end else ev_err = 1'b1;
        C_COLGO:
          if (st_q == S_CO_CNF) begin
            ev_op = OP_COLOUT;  st_n = S_RD_OUT;
          end else ev_err = 1'b1;
        C_RELOC:
          if (st_q == S_PG_DAT) begin
            st_n = S_PG_REL;  a_clr = 1'b1;
          end else if (st_q == S_CB_WT) begin
            st_n = S_CB_ADR;  a_clr = 1'b1;  b_clr = 1'b1;
          end else ev_err = 1'b1;
        C_NEXT:
          if (st_q == S_PG_DAT) st_n = S_PG_NXT;
          else ev_err = 1'b1;
        C_PGGO:
          if (st_q == S_PG_DAT || st_q == S_CB_DAT) begin
            ev_op = (st_q == S_PG_DAT) ? OP_PROG : OP_CBPROG;
            busy_set = 1'b1;  st_n = S_IDLE;
          end else ev_err = 1'b1;
        C_ERGO:
          if (st_q == S_ER_CNF) begin
            ev_op = OP_ERASE;  busy_set = 1'b1;  st_n = S_IDLE;
          end else ev_err = 1'b1;
        default: ev_err = 1'b1;
      endcase
    end else if (is_adr) begin
      case (st_q)
        S_RD_ADR, S_PG_ADR, S_CB_ADR, S_CO_ADR, S_PG_REL, S_ER_ADR: begin
          a_take = 1'b1;
          if (a_last) begin
            case (st_q)
              S_RD_ADR: begin st_n = S_RD_CNF; b_wr = 1'b1; end
              S_PG_ADR: begin st_n = S_PG_DAT; b_wr = 1'b1; p_load = 1'b1; end
              S_CB_ADR: begin st_n = S_CB_DAT; b_wr = 1'b1; p_load = 1'b1; end
              S_CO_ADR: st_n = S_CO_CNF;
              S_PG_REL: begin st_n = S_PG_DAT; p_load = 1'b1; end
              default:  begin st_n = S_ER_CNF; b_wr = 1'b1; b_erase = 1'b1; end
            endcase
          end
        end
        default: ev_err = 1'b1;
      endcase
    end else if (is_dat) begin
      if (st_q == S_PG_DAT || st_q == S_CB_DAT) begin
        ev_dat = 1'b1;  p_inc = 1'b1;
      end else ev_err = 1'b1;
    end
    if (ev_err && !busy_q) st_n = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      busy_q     <= 1'b0;
      ptr_q      <= '0;
      cur_bank_q <= '0;
      seq_err    <= 1'b0;
      op_valid   <= 1'b0;
      op_code    <= '0;
      op_mask    <= '0;
      op_col     <= '0;
      op_dcol    <= '0;
      dat_valid  <= 1'b0;
      dat_bank   <= '0;
      dat_col    <= '0;
      dat_byte   <= '0;
    end else begin
      st_q <= st_n;
      if (busy_set)                busy_q <= 1'b1;
      else if (busy_clr || done_i) busy_q <= 1'b0;
      if (p_load)     ptr_q <= col_nx;
      else if (p_inc) ptr_q <= ptr_q + 1'b1;
      if (b_wr) cur_bank_q <= row_nx[BANK_W-1:0];
      seq_err   <= ev_err;
      op_valid  <= (ev_op != OP_NONE);
      op_code   <= ev_op;
      op_mask   <= (ev_op == OP_READ || ev_op == OP_CBREAD || ev_op == OP_PROG ||
                    ev_op == OP_CBPROG || ev_op == OP_ERASE) ? mask : '0;
      op_col    <= col_q;
      op_dcol   <= ptr_q;
      dat_valid <= ev_dat;
      dat_bank  <= cur_bank_q;
      dat_col   <= ptr_q;
      dat_byte  <= bus_d;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/flash_seq_checker.sv
`timescale 1ns/1ps
module flash_seq_checker #(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done_i,
  input logic             busy_o,
  input logic             seq_err,
  input logic             op_valid,
  input logic [3:0]       op_code,
  input logic [NBANK-1:0] op_mask,
  input logic             dat_valid
);
  assert_single_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_valid, dat_valid, seq_err}));

  assert_busy_launch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> op_valid && (op_code inside {4'd1, 4'd2, 4'd4, 4'd5, 4'd6}));

  assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done_i |=> busy_o || (op_valid && op_code == 4'd8));

  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 4'd8 |-> !busy_o && op_mask == '0);

  assert_one_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == 4'd1 || op_code == 4'd2) |-> $countones(op_mask) == 1);

  assert_erase_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 4'd6 |-> $countones(op_mask) == 1);

  assert_chain_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 4'd4 |-> op_mask != '0);

  assert_status_keep_R12: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 4'd7 && !$past(done_i) |-> busy_o == $past(busy_o) && op_mask == '0);
endmodule

bind flash_seq_decoder flash_seq_checker #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .done_i(done_i), .busy_o(busy_o),
  .seq_err(seq_err), .op_valid(op_valid), .op_code(op_code),
  .op_mask(op_mask), .dat_valid(dat_valid)
);

// File: tb/flash_seq_decoder_test.sv
`timescale 1ns/1ps
module flash_seq_decoder_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, cle = 1'b0, ale = 1'b0, done_i = 1'b0;
  logic [7:0]  bus_d = '0;
  logic        busy_o, seq_err, op_valid, dat_valid;
  logic [3:0]  op_code, op_mask;
  logic [15:0] op_col, op_dcol, dat_col;
  logic [63:0] op_pages;
  logic [1:0]  dat_bank;
  logic [7:0]  dat_byte;

  always #2.5 clk = ~clk;

  flash_seq_decoder uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cle(cle), .ale(ale),
    .bus_d(bus_d), .done_i(done_i), .busy_o(busy_o), .seq_err(seq_err),
    .op_valid(op_valid), .op_code(op_code), .op_mask(op_mask),
    .op_col(op_col), .op_pages(op_pages), .op_dcol(op_dcol),
    .dat_valid(dat_valid), .dat_bank(dat_bank), .dat_col(dat_col),
    .dat_byte(dat_byte)
  );

  typedef struct {
    int          kind;    // 0 op, 1 data, 2 refusal
    logic [3:0]  code;
    logic [3:0]  mask;
    logic [63:0] pg;
    logic [15:0] col;
    bit          ccol;
    logic [15:0] dcol;
    bit          cdcol;
    logic [1:0]  bank;
    logic [7:0]  b;
    string       req;
  } exp_t;

  exp_t q[$];
  int nchk = 0, nfail = 0;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] pgv(input int bank, input logic [15:0] page);
    return 64'(page) << (bank * 16);
  endfunction

  task automatic ex_op(input logic [3:0] code, input logic [3:0] mask, input logic [63:0] pg,
                       input logic [15:0] col, input bit ccol, input logic [15:0] dcol,
                       input bit cdcol, input string req);
    exp_t e;
    e.kind = 0; e.code = code; e.mask = mask; e.pg = pg; e.col = col; e.ccol = ccol;
    e.dcol = dcol; e.cdcol = cdcol; e.bank = '0; e.b = '0; e.req = req;
    q.push_back(e);
  endtask

  task automatic ex_dat(input logic [1:0] bank, input logic [15:0] col, input logic [7:0] b,
                        input string req);
    exp_t e;
    e.kind = 1; e.code = '0; e.mask = '0; e.pg = '0; e.col = col; e.ccol = 1'b1;
    e.dcol = '0; e.cdcol = 1'b0; e.bank = bank; e.b = b; e.req = req;
    q.push_back(e);
  endtask

  task automatic ex_err(input string req);
    exp_t e;
    e.kind = 2; e.code = '0; e.mask = '0; e.pg = '0; e.col = '0; e.ccol = 1'b0;
    e.dcol = '0; e.cdcol = 1'b0; e.bank = '0; e.b = '0; e.req = req;
    q.push_back(e);
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] b);
    @(negedge clk);
    cle = c; ale = a; bus_d = b; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cle = 1'b0; ale = 1'b0;
  endtask
  task automatic cmd(input logic [7:0] b); wr(1'b1, 1'b0, b); endtask
  task automatic adr(input logic [7:0] b); wr(1'b0, 1'b1, b); endtask
  task automatic dat(input logic [7:0] b); wr(1'b0, 1'b0, b); endtask
  task automatic adr4(input logic [15:0] c, input logic [15:0] r);
    adr(c[7:0]); adr(c[15:8]); adr(r[7:0]); adr(r[15:8]);
  endtask
  task automatic finish_op();
    @(negedge clk); done_i = 1'b1;
    @(negedge clk); done_i = 1'b0;
    @(negedge clk);
  endtask

  // monitor: pops the scoreboard whenever the design emits an event
  always @(negedge clk) begin
    if (rst_n && (op_valid || dat_valid || seq_err)) begin
      nchk++;
      if (q.size() == 0) begin
        nfail++;
        $display("FAIL unexpected event: op=%0b(%0d) dat=%0b err=%0b, expected none",
                 op_valid, op_code, dat_valid, seq_err);
      end else begin
        exp_t e;
        bit bad;
        e = q.pop_front();
        bad = 1'b0;
        if (e.kind == 0) begin
          if (!op_valid || op_code !== e.code || op_mask !== e.mask) bad = 1'b1;
          for (int k = 0; k < 4; k++)
            if (e.mask[k] && op_pages[k*16 +: 16] !== e.pg[k*16 +: 16]) bad = 1'b1;
          if (e.ccol && op_col !== e.col) bad = 1'b1;
          if (e.cdcol && op_dcol !== e.dcol) bad = 1'b1;
          if (bad) begin
            nfail++;
            $display("FAIL %s: op got code=%0d mask=%b pages=%h col=%h dcol=%h, expected code=%0d mask=%b pages=%h col=%h dcol=%h",
                     e.req, op_code, op_mask, op_pages, op_col, op_dcol,
                     e.code, e.mask, e.pg, e.col, e.dcol);
          end
        end else if (e.kind == 1) begin
          if (!dat_valid || dat_bank !== e.bank || dat_col !== e.col || dat_byte !== e.b) begin
            nfail++;
            $display("FAIL %s: data got v=%0b bank=%0d col=%h byte=%h, expected bank=%0d col=%h byte=%h",
                     e.req, dat_valid, dat_bank, dat_col, dat_byte, e.bank, e.col, e.b);
          end
        end else if (!seq_err) begin
          nfail++;
          $display("FAIL %s: got op=%0b dat=%0b err=0, expected err=1",
                   e.req, op_valid, dat_valid);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy_o, 0);
    chk("R1 strobes", {op_valid, dat_valid, seq_err}, 0);
    ex_err("R1 confirm in idle"); cmd(8'h30);

    // R3 page read, bank 1
    cmd(8'h00); adr4(16'h1234, 16'h0005);
    ex_op(4'd1, 4'b0010, pgv(1, 16'h0005), 16'h1234, 1, 0, 0, "R3 read"); cmd(8'h30);
    chk("R11 busy after read", busy_o, 1);
    ex_err("R11 relocate while busy"); cmd(8'h05);
    ex_err("R11 address while busy"); adr(8'h00);
    ex_op(4'd7, 4'b0000, 0, 0, 0, 0, 0, "R12 status busy"); cmd(8'h70);
    chk("R12 busy kept", busy_o, 1);
    finish_op();
    chk("R11 busy cleared", busy_o, 0);

    // R4 column relocation, state kept through busy refusals
    cmd(8'h05); adr(8'h10); adr(8'h00);
    ex_op(4'd3, 4'b0000, 0, 16'h0010, 1, 0, 0, "R4 colout a"); cmd(8'hE0);
    cmd(8'h05); adr(8'hFF); adr(8'h07);
    ex_op(4'd3, 4'b0000, 0, 16'h07FF, 1, 0, 0, "R4 colout b"); cmd(8'hE0);
    cmd(8'h05); adr(8'h10); adr(8'h00);
    ex_op(4'd3, 4'b0000, 0, 16'h0010, 1, 0, 0, "R4 colout repeat"); cmd(8'hE0);

    // R5 program with relocation, bank 0
    cmd(8'h80); adr4(16'h0000, 16'h0008);
    ex_dat(2'd0, 16'h0000, 8'hAA, "R5 data0"); dat(8'hAA);
    ex_dat(2'd0, 16'h0001, 8'hBB, "R5 data1"); dat(8'hBB);
    cmd(8'h85); adr(8'h40); adr(8'h00);
    ex_dat(2'd0, 16'h0040, 8'hCC, "R5 relocated data"); dat(8'hCC);
    ex_op(4'd4, 4'b0001, pgv(0, 16'h0008), 16'h0040, 1, 16'h0041, 1, "R5 program"); cmd(8'h10);
    finish_op();

    // R6 multi-bank chain, bank 3 revisited
    cmd(8'h80); adr4(16'h0000, 16'h0013);
    ex_dat(2'd3, 16'h0000, 8'h01, "R6 bank3 data"); dat(8'h01);
    cmd(8'h11);
    cmd(8'h80); adr4(16'h0005, 16'h0021);
    ex_dat(2'd1, 16'h0005, 8'h02, "R6 bank1 data"); dat(8'h02);
    cmd(8'h11);
    cmd(8'h80); adr4(16'h0000, 16'h0033);
    ex_dat(2'd3, 16'h0000, 8'h03, "R6 bank3 again"); dat(8'h03);
    ex_op(4'd4, 4'b1010, pgv(3, 16'h0033) | pgv(1, 16'h0021), 16'h0000, 1, 16'h0001, 1,
          "R6 chained program"); cmd(8'h10);
    finish_op();

    // R7 copy-back, bank 2
    cmd(8'h00); adr4(16'h0000, 16'h0102);
    ex_op(4'd2, 4'b0100, pgv(2, 16'h0102), 16'h0000, 1, 0, 0, "R7 source load"); cmd(8'h35);
    chk("R7 busy", busy_o, 1);
    finish_op();
    cmd(8'h85); adr4(16'h0000, 16'h0106);
    ex_dat(2'd2, 16'h0000, 8'h5A, "R7 update"); dat(8'h5A);
    ex_op(4'd5, 4'b0100, pgv(2, 16'h0106), 16'h0000, 1, 16'h0001, 1, "R7 copy program"); cmd(8'h10);
    finish_op();

    // R8 erase, row 7 -> block base 3
    cmd(8'h60); adr(8'h07); adr(8'h00);
    ex_op(4'd6, 4'b1000, pgv(3, 16'h0003), 0, 0, 0, 0, "R8 erase"); cmd(8'hD0);
    finish_op();

    // R10 undefined bytes
    ex_err("R10 undefined idle"); cmd(8'h42);
    cmd(8'h00); adr4(16'h0000, 16'h0001);
    ex_err("R10 undefined mid"); cmd(8'h9C);
    ex_err("R10 back to idle"); cmd(8'h30);

    // R13 orphan and surplus address cycles, stray data
    ex_err("R13 orphan address"); adr(8'h12);
    cmd(8'h00); adr4(16'h0000, 16'h0001);
    ex_err("R13 surplus address"); adr(8'h00);
    ex_err("R13 idle after surplus"); cmd(8'h30);
    ex_err("R13 stray data"); dat(8'h77);

    // R6 bad follower after 11h
    cmd(8'h80); adr4(16'h0000, 16'h0002);
    cmd(8'h11);
    ex_err("R6 bad follower"); cmd(8'h60);

    // R2 both enables high, and no strobe
    ex_err("R2 both enables"); wr(1'b1, 1'b1, 8'h00);
    @(negedge clk); cle = 1'b1; bus_d = 8'h42;
    @(negedge clk); cle = 1'b0;
    chk("R2 no strobe no byte", {op_valid, dat_valid, seq_err}, 0);

    // R9 abort mid-load and during busy
    cmd(8'h80); adr4(16'h0000, 16'h0001);
    ex_dat(2'd1, 16'h0000, 8'h99, "R9 load"); dat(8'h99);
    ex_op(4'd8, 4'b0000, 0, 0, 0, 0, 0, "R9 abort load"); cmd(8'hFF);
    ex_err("R9 idle after abort"); cmd(8'h10);
    cmd(8'h60); adr(8'h04); adr(8'h00);
    ex_op(4'd6, 4'b0001, pgv(0, 16'h0000), 0, 0, 0, 0, "R8 erase pair"); cmd(8'hD0);
    ex_op(4'd8, 4'b0000, 0, 0, 0, 0, 0, "R9 abort busy"); cmd(8'hFF);
    chk("R9 busy cleared", busy_o, 0);
    ex_op(4'd7, 4'b0000, 0, 0, 0, 0, 0, "R12 status idle"); cmd(8'h70);

    repeat (4) @(negedge clk);
    chk("scoreboard drained", 64'(q.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule